// File: doc/BRIEF.md
# Deferred Video Memory Write Queue

This block sits between a processor bus and a video memory that a pixel unit also reads. Processor writes whose address falls inside a fixed window are caught and held in a small first-in first-out queue. Each held entry carries the video memory address and the data byte. Entries are then written into video memory, one at a time, only during the slots the pixel unit leaves free. The processor can therefore update video memory while the picture is being drawn, and not only during blanking.

The pixel unit uses the video memory bus on alternate slots. The block watches one input that is high while the pixel unit owns the bus. When that input falls, a free slot begins. The block then waits a fixed number of fast clocks and pulses an active-low write strobe inside that slot. The strobe retires the oldest entry. Full, empty and sticky overflow flags are brought out.

Top module: `vram_defer_queue`

## Requirements
- R1: A processor write (`cpu_we` high for one clock) is captured only when `cpu_addr` lies in 0x5000..0x7FFF inclusive. Writes to any other address leave the queue empty and produce no strobe.
- R2: A captured entry reaches video memory with `vram_addr` equal to `cpu_addr` minus 0x5000, as 14 bits, and with `vram_data` equal to `cpu_data`. So 0x5000 maps to 0x0000 and 0x7FFF maps to 0x2FFF.
- R3: Entries are written to video memory in the order they were captured.
- R4: `vram_we_n` is low only while `pix_rd` is low. `pix_rd` high means the pixel unit owns the bus.
- R5: `vram_we_n` goes low DLY clocks after the first rising edge at which `pix_rd` is sampled low. It then stays low for exactly LEN clocks.
- R6: At most one entry is retired per low period of `pix_rd`. Remaining entries wait for later free slots.
- R7: `vram_addr` and `vram_data` hold steady for the whole time `vram_we_n` is low.
- R8: `q_full` is high when DEPTH entries are held. A write into the window while full is dropped and sets `q_overflow`. `q_overflow` stays high until reset.
- R9: A capture and a retirement in the same clock both take effect. No entry is lost or duplicated.
- R10: `q_empty` is high when no entries are held. `vram_we_n` is high whenever the queue is empty.
- R11: During and after reset the queue is empty, `q_full` and `q_overflow` are low, and `vram_we_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_we | input | 1 | Processor write strobe, one clock per write |
| cpu_addr | input | 16 | Processor write address |
| cpu_data | input | 8 | Processor write data |
| pix_rd | input | 1 | High while the pixel unit owns the video memory bus |
| vram_addr | output | 14 | Video memory address of the oldest entry |
| vram_data | output | 8 | Video memory data of the oldest entry |
| vram_we_n | output | 1 | Active-low video memory write strobe |
| q_full | output | 1 | Queue holds DEPTH entries |
| q_empty | output | 1 | Queue holds no entries |
| q_overflow | output | 1 | Sticky: a window write was dropped |

## Verification
The bench builds the block with DEPTH=4, DLY=2 and LEN=2. The short queue lets a handful of writes reach the full and overflow states. The two-clock delay and strobe width make an off-by-one in the strobe placement or width visible. The bench can hold `pix_rd` high to stop all draining, which lets it fill the queue at will. It can also place a processor write on the exact clock of a retirement, and it walks both edges of the address window.

// File: rtl/vdq_pkg.sv
package vdq_pkg;
  localparam int CPU_AW = 16;
  localparam int DW     = 8;
  localparam int VAW    = 14;

  typedef struct packed {
    logic [VAW-1:0] addr;
    logic [DW-1:0]  data;
  } vdq_entry_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_LOW  = 2'd2
  } vdq_state_t;
endpackage

// File: rtl/vdq_window.sv
module vdq_window
  import vdq_pkg::*;
#(
  parameter logic [CPU_AW-1:0] WIN_LO = 16'h5000,
  parameter logic [CPU_AW-1:0] WIN_HI = 16'h7FFF
) (
  input  logic              cpu_we,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [DW-1:0]     cpu_data,
  output logic              hit,
  output vdq_entry_t        entry
);
  logic in_range;

  always_comb begin
    in_range   = (cpu_addr >= WIN_LO) && (cpu_addr <= WIN_HI);
    hit        = cpu_we && in_range;
    entry.addr = VAW'(cpu_addr - WIN_LO);
    entry.data = cpu_data;
  end
endmodule

// File: rtl/vdq_fifo.sv
module vdq_fifo
  import vdq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push_req,
  input  vdq_entry_t push_entry,
  input  logic       pop,
  output vdq_entry_t head,
  output logic       full,
  output logic       empty,
  output logic       overflow
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  vdq_entry_t       mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, wr_ptr_nxt;
  logic [PTR_W-1:0] rd_ptr, rd_ptr_nxt;
  logic [CNT_W-1:0] count, count_nxt;
  logic             ovf_q, ovf_nxt;
  logic             push_ok, pop_ok;

  always_comb begin
    full    = (count == CNT_FULL);
    empty   = (count == '0);
    push_ok = push_req && !full;
    pop_ok  = pop && !empty;
    head    = mem[rd_ptr];

    wr_ptr_nxt = wr_ptr;
    if (push_ok) begin
      wr_ptr_nxt = (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
    end
    rd_ptr_nxt = rd_ptr;
    if (pop_ok) begin
      rd_ptr_nxt = (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
    end
    count_nxt = count;
    if (push_ok && !pop_ok) begin
      count_nxt = count + 1'b1;
    end else if (!push_ok && pop_ok) begin
      count_nxt = count - 1'b1;
    end
    ovf_nxt = ovf_q || (push_req && full);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      wr_ptr <= wr_ptr_nxt;
      rd_ptr <= rd_ptr_nxt;
      count  <= count_nxt;
      ovf_q  <= ovf_nxt;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push_ok && (wr_ptr == PTR_W'(g))) begin
        mem[g] <= push_entry;
      end
    end
  end

  assign overflow = ovf_q;

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_FULL); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow); // R8
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push_req && !pop) |=> (full && overflow)); // R8
  AST_PUSH_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && !full && pop && !empty) |=> $stable(count)); // R9
  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !pop); // R10
endmodule

// File: rtl/vdq_strobe.sv
module vdq_strobe
  import vdq_pkg::*;
#(
  parameter int DLY = 2,
  parameter int LEN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pix_rd,
  input  logic empty,
  output logic we_n,
  output logic pop
);
  localparam int SPAN  = (DLY > LEN) ? DLY : LEN;
  localparam int CNT_W = (SPAN > 1) ? $clog2(SPAN + 1) : 1;
  localparam logic [CNT_W-1:0] DLY_LAST = CNT_W'(DLY - 1);
  localparam logic [CNT_W-1:0] LEN_LAST = CNT_W'(LEN - 1);

  vdq_state_t       state, state_nxt;
  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic             pix_q;
  logic             rd_fall;

  always_comb begin
    rd_fall   = pix_q && !pix_rd;
    state_nxt = state;
    cnt_nxt   = cnt;
    pop       = 1'b0;
    case (state)
      ST_IDLE: begin
        if (rd_fall && !empty) begin
          cnt_nxt   = '0;
          state_nxt = (DLY == 0) ? ST_LOW : ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (pix_rd) begin
          state_nxt = ST_IDLE;
        end else if (cnt == DLY_LAST) begin
          cnt_nxt   = '0;
          state_nxt = ST_LOW;
        end else begin
          cnt_nxt = cnt + 1'b1;
        end
      end
      ST_LOW: begin
        if (cnt == LEN_LAST) begin
          pop       = 1'b1;
          state_nxt = ST_IDLE;
        end else begin
          cnt_nxt = cnt + 1'b1;
        end
      end
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      pix_q <= 1'b1;
    end else begin
      state <= state_nxt;
      cnt   <= cnt_nxt;
      pix_q <= pix_rd;
    end
  end

  assign we_n = (state != ST_LOW);

  AST_STROBE_IN_FREE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !pix_rd); // R4
  AST_STROBE_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !empty); // R10
  AST_POP_ENDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> we_n); // R6
endmodule

// File: rtl/vram_defer_queue.sv
module vram_defer_queue
  import vdq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DLY   = 2,
  parameter int LEN   = 2,
  parameter logic [15:0] WIN_LO = 16'h5000,
  parameter logic [15:0] WIN_HI = 16'h7FFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_we,
  input  logic [15:0] cpu_addr,
  input  logic [7:0]  cpu_data,
  input  logic        pix_rd,
  output logic [13:0] vram_addr,
  output logic [7:0]  vram_data,
  output logic        vram_we_n,
  output logic        q_full,
  output logic        q_empty,
  output logic        q_overflow
);
  logic [1:0] rst_sync;
  logic       srst_n;
  logic       hit;
  logic       pop;
  vdq_entry_t in_entry;
  vdq_entry_t head;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign srst_n = rst_sync[1];

  vdq_window #(.WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_window (
    .cpu_we  (cpu_we),
    .cpu_addr(cpu_addr),
    .cpu_data(cpu_data),
    .hit     (hit),
    .entry   (in_entry)
  );

  vdq_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (srst_n),
    .push_req  (hit),
    .push_entry(in_entry),
    .pop       (pop),
    .head      (head),
    .full      (q_full),
    .empty     (q_empty),
    .overflow  (q_overflow)
  );

  vdq_strobe #(.DLY(DLY), .LEN(LEN)) u_strobe (
    .clk  (clk),
    .rst_n(srst_n),
    .pix_rd(pix_rd),
    .empty(q_empty),
    .we_n (vram_we_n),
    .pop  (pop)
  );

  assign vram_addr = head.addr;
  assign vram_data = head.data;

  AST_HOLD_DURING_STROBE: assert property (@(posedge clk) disable iff (!srst_n)
    (!vram_we_n && $past(!vram_we_n)) |-> ($stable(vram_addr) && $stable(vram_data))); // R7
  AST_OUTSIDE_IGNORED: assert property (@(posedge clk) disable iff (!srst_n)
    (cpu_we && ((cpu_addr < WIN_LO) || (cpu_addr > WIN_HI)) && q_empty && vram_we_n) |=> q_empty); // R1
endmodule

// File: tb/vram_defer_queue_test.sv
module vram_defer_queue_test;
  localparam int DEPTH = 4;
  localparam int DLY   = 2;
  localparam int LEN   = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_we;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_data;
  logic        pix_rd;
  logic [13:0] vram_addr;
  logic [7:0]  vram_data;
  logic        vram_we_n;
  logic        q_full, q_empty, q_overflow;

  int checks = 0;
  int failures = 0;
  logic slots_on = 1'b0;
  logic mon_on = 1'b0;
  int mon_strobes = 0;
  logic [21:0] exp_q[$];

  always #4 clk = ~clk;

  vram_defer_queue #(.DEPTH(DEPTH), .DLY(DLY), .LEN(LEN)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_data(cpu_data), .pix_rd(pix_rd), .vram_addr(vram_addr),
    .vram_data(vram_data), .vram_we_n(vram_we_n), .q_full(q_full),
    .q_empty(q_empty), .q_overflow(q_overflow)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // pixel unit schedule: 8 clocks owning the bus, 8 clocks free
  initial begin
    int phase = 0;
    pix_rd = 1'b1;
    forever begin
      @(posedge clk); #1;
      if (!slots_on) begin
        pix_rd = 1'b1;
        phase = 0;
      end else begin
        phase++;
        if (phase == 8) begin
          pix_rd = ~pix_rd;
          phase = 0;
        end
      end
    end
  end

  // strobe monitor
  initial begin
    int lowcnt = 0;
    int width = 0;
    int slot_cnt = 0;
    bit in_strobe = 0;
    logic [13:0] cap_a = '0;
    logic [7:0]  cap_d = '0;
    forever begin
      @(negedge clk);
      if (pix_rd) begin
        lowcnt = 0;
        slot_cnt = 0;
      end else begin
        lowcnt++;
      end
      if (mon_on && !vram_we_n && !in_strobe) begin
        in_strobe = 1;
        width = 1;
        mon_strobes++;
        chk(!pix_rd, "R4 strobe in pixel slot", pix_rd, 0);
        chk(lowcnt == DLY + 2, "R5 strobe delay", lowcnt, DLY + 2);
        chk(slot_cnt == 0, "R6 one write per slot", slot_cnt, 0);
        slot_cnt++;
        chk(!q_empty, "R10 strobe with empty queue", q_empty, 0);
        if (exp_q.size() == 0) begin
          chk(0, "R1 unexpected write", {vram_addr, vram_data}, 0);
        end else begin
          chk({vram_addr, vram_data} == exp_q[0], "R3 R2 entry order/value",
              {vram_addr, vram_data}, exp_q[0]);
          void'(exp_q.pop_front());
        end
        cap_a = vram_addr;
        cap_d = vram_data;
      end else if (mon_on && !vram_we_n && in_strobe) begin
        width++;
        chk(vram_addr == cap_a && vram_data == cap_d, "R7 hold during strobe",
            {vram_addr, vram_data}, {cap_a, cap_d});
        chk(!pix_rd, "R4 strobe in pixel slot", pix_rd, 0);
      end else if (vram_we_n && in_strobe) begin
        in_strobe = 0;
        chk(width == LEN, "R5 strobe width", width, LEN);
      end
    end
  end

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    cpu_we = 1'b1; cpu_addr = a; cpu_data = d;
    if (a >= 16'h5000 && a <= 16'h7FFF && exp_q.size() < DEPTH) begin
      logic [13:0] va;
      va = 14'(a - 16'h5000);
      exp_q.push_back({va, d});
    end
    @(posedge clk); #1;
    cpu_we = 1'b0;
  endtask

  task automatic drain(input string tag);
    int n = 0;
    slots_on = 1'b1;
    while (!(q_empty && vram_we_n && exp_q.size() == 0) && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(n < 3000, tag, n, 0);
    // stop only once the pixel unit owns the bus again
    while (!pix_rd) @(negedge clk);
    slots_on = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cpu_we = 1'b0; cpu_addr = '0; cpu_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(q_empty && !q_full && !q_overflow && vram_we_n, "R11 reset state",
        {q_empty, q_full, q_overflow, vram_we_n}, 4'b1001);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(q_empty && !q_full && !q_overflow && vram_we_n, "R11 after release",
        {q_empty, q_full, q_overflow, vram_we_n}, 4'b1001);
  endtask

  task automatic test_window();
    cpu_write(16'h4FFF, 8'h11); @(negedge clk);
    chk(q_empty, "R1 below window ignored", q_empty, 1);
    cpu_write(16'h8000, 8'h22); @(negedge clk);
    chk(q_empty, "R1 above window ignored", q_empty, 1);
    cpu_write(16'h0000, 8'h33);
    cpu_write(16'hFFFF, 8'h44); @(negedge clk);
    chk(q_empty && vram_we_n, "R1 far addresses ignored", q_empty, 1);
    cpu_write(16'h5000, 8'hA5); @(negedge clk);
    chk(!q_empty, "R1 low edge captured", q_empty, 0);
    cpu_write(16'h7FFF, 8'h5A);
    drain("R2 window edges drained");
    chk(mon_strobes == 2, "R1 only window writes reach memory", mon_strobes, 2);
  endtask

  task automatic test_order();
    int base = mon_strobes;
    cpu_write(16'h6123, 8'h01);
    cpu_write(16'h5400, 8'h02);
    cpu_write(16'h7010, 8'h03);
    slots_on = 1'b1;
    wait (mon_strobes == base + 1);
    @(posedge vram_we_n); @(negedge clk);
    chk(!q_empty, "R6 entries wait for next slot", q_empty, 0);
    drain("R3 order drain finished");
    chk(mon_strobes == base + 3, "R3 all entries written", mon_strobes - base, 3);
  endtask

  task automatic test_full();
    int base = mon_strobes;
    cpu_write(16'h5001, 8'hB0);
    cpu_write(16'h5002, 8'hB1);
    cpu_write(16'h5003, 8'hB2);
    @(negedge clk);
    chk(!q_full, "R8 not full below depth", q_full, 0);
    cpu_write(16'h5004, 8'hB3); @(negedge clk);
    chk(q_full && !q_overflow, "R8 full at depth", {q_full, q_overflow}, 2'b10);
    cpu_write(16'h5005, 8'hB4); @(negedge clk);
    chk(q_full && q_overflow, "R8 drop sets overflow", {q_full, q_overflow}, 2'b11);
    drain("R8 drain after overflow");
    chk(mon_strobes == base + 4, "R8 dropped write absent", mon_strobes - base, 4);
    chk(q_overflow && q_empty && !q_full, "R8 overflow sticky",
        {q_overflow, q_empty, q_full}, 3'b110);
  endtask

  task automatic test_same_cycle();
    int base = mon_strobes;
    cpu_write(16'h6000, 8'hC0);
    cpu_write(16'h6001, 8'hC1);
    slots_on = 1'b1;
    @(negedge clk);
    while (vram_we_n) @(negedge clk);
    // strobe began; its last clock is the second edge from here
    @(posedge clk); #1;
    cpu_we = 1'b1; cpu_addr = 16'h6002; cpu_data = 8'hC2;
    exp_q.push_back({14'h1002, 8'hC2});
    @(posedge clk); #1;
    cpu_we = 1'b0;
    drain("R9 drain after same-cycle push/pop");
    chk(mon_strobes == base + 3, "R9 no loss or duplicate", mon_strobes - base, 3);
    chk(q_empty && vram_we_n, "R10 empty and strobe high", {q_empty, vram_we_n}, 2'b11);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    mon_on = 1'b1;
    test_window();
    test_order();
    test_full();
    test_same_cycle();
    mon_on = 1'b0;
    do_reset();
    chk(!q_overflow, "R8 overflow cleared by reset", q_overflow, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule